// File: doc/BRIEF.md
# 100 Mb/s Transmit Code-Group Framer

This block sits on the transmit side of a 100 Mb/s twisted-pair link, between the media-independent nibble interface and the scrambler. On every rising edge of the transmit clock it takes in one nibble, a transmit-enable bit and a transmit-error bit. On every edge it also puts out one 5-bit code group. When no frame is being sent, it sends the idle group so that the far end stays locked. It marks the start of a frame by putting the J and K delimiters in place of the first two preamble nibbles. It closes the frame with the T and R delimiters and then goes back to idle.

A nibble that arrives with the error bit set inside the data part of a frame is sent as an invalid symbol. A raw symbol mode skips both the framing and the table. In that mode the error pin acts as a fifth data bit and the 5-bit value goes out unchanged. The line takes one symbol per clock, so the stream has no valid/ready handshake and no back-pressure. Input is accepted on every edge and output is produced on every edge.

Top module: `tx_4b5b_framer`

## Requirements
- R1: While reset is asserted, and afterwards until a frame starts, the output is the idle group 11111.
- R2: While the transmit enable is low and no delimiter is pending, the output is idle 11111 on every cycle.
- R3: The first two nibbles of a frame leave the block as J = 11000 and then K = 10001, whatever their values.
- R4: The third and later nibbles of a frame are encoded as follows: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R5: The first cycle sampled with enable low after a frame's data produces T = 01101. The next cycle produces R = 00111. Idle follows.
- R6: A nibble sampled at clock edge k appears as its code group on the output register after edge k+1. The latency is constant, including for delimiters.
- R7: A data nibble (the third or later) sampled with the error bit high is replaced by the invalid symbol 00100. Only that nibble is replaced.
- R8: A frame that ends after one or two nibbles still leaves as the full sequence J, K, T, R, then idle.
- R9: While raw mode is sampled high, the output is {error bit, nibble} from the same sample, with the same latency. Framing is abandoned, and idle resumes once raw mode is dropped.
- R10: An error bit that arrives with either of the first two nibbles has no effect, and the delimiter J or K is still sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock, one symbol per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mii_txd | input | 4 | Transmit nibble |
| mii_tx_en | input | 1 | Frame enable |
| mii_tx_er | input | 1 | Transmit error; fifth symbol bit in raw mode |
| sym_raw | input | 1 | Raw 5-bit symbol mode, bypassing framer and table |
| code_o | output | 5 | Registered 5-bit code group |

## Verification
The bench drives frames whose payload runs through every nibble value, so a wrong table entry shows up as a mismatch at a known position. It also drives frames of one and two nibbles, which tell the short-frame path apart from the normal T/R path. Errors are placed on a preamble nibble and on a data nibble: the first case must leave K unchanged and the second must produce exactly one invalid symbol, which also exposes a stuck error path. Raw symbols between frames show that the bypass keeps the same latency and that framing restarts cleanly afterwards.

// File: rtl/tx4b5b_pkg.sv
package tx4b5b_pkg;
  localparam int NIB_W = 4;
  localparam int SYM_W = NIB_W + 1;
  typedef logic [SYM_W-1:0] sym_t;
  typedef logic [NIB_W-1:0] nib_t;

  localparam sym_t SYM_IDLE = 5'b11111;
  localparam sym_t SYM_J    = 5'b11000;
  localparam sym_t SYM_K    = 5'b10001;
  localparam sym_t SYM_T    = 5'b01101;
  localparam sym_t SYM_R    = 5'b00111;
  localparam sym_t SYM_BAD  = 5'b00100;

  typedef enum logic [2:0] {
    FS_IDLE, FS_K, FS_DATA, FS_T, FS_R
  } fstate_t;

  typedef struct packed {
    logic en;
    logic er;
    logic raw;
    nib_t dat;
  } samp_t;
endpackage

// File: rtl/tx_in_stage.sv
module tx_in_stage
  import tx4b5b_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  samp_t in_s,
  output samp_t out_s
);
  always_ff @(posedge clk) begin
    if (!rst_n) out_s <= '0;
    else        out_s <= in_s;
  end
endmodule

// File: rtl/nib_encoder.sv
module nib_encoder
  import tx4b5b_pkg::*;
(
  input  nib_t nib,
  output sym_t grp
);
  always_comb begin
    case (nib)
      4'h0: grp = 5'b11110;
      4'h1: grp = 5'b01001;
      4'h2: grp = 5'b10100;
      4'h3: grp = 5'b10101;
      4'h4: grp = 5'b01010;
      4'h5: grp = 5'b01011;
      4'h6: grp = 5'b01110;
      4'h7: grp = 5'b01111;
      4'h8: grp = 5'b10010;
      4'h9: grp = 5'b10011;
      4'hA: grp = 5'b10110;
      4'hB: grp = 5'b10111;
      4'hC: grp = 5'b11010;
      4'hD: grp = 5'b11011;
      4'hE: grp = 5'b11100;
      default: grp = 5'b11101;
    endcase
  end
endmodule

// File: rtl/frame_ctrl.sv
module frame_ctrl
  import tx4b5b_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  samp_t smp,
  output sym_t  sym_nxt
);
  fstate_t state_q, state_d;
  sym_t    data_grp;

  nib_encoder u_enc (.nib(smp.dat), .grp(data_grp));

  always_comb begin
    state_d = state_q;
    sym_nxt = SYM_IDLE;
    case (state_q)
      FS_IDLE: if (smp.en) begin
        sym_nxt = SYM_J;
        state_d = FS_K;
      end
      FS_K: begin
        sym_nxt = SYM_K;
        state_d = smp.en ? FS_DATA : FS_T;
      end
      FS_DATA: if (smp.en) begin
        sym_nxt = smp.er ? SYM_BAD : data_grp;
      end else begin
        sym_nxt = SYM_T;
        state_d = FS_R;
      end
      FS_T: begin
        sym_nxt = SYM_T;
        state_d = FS_R;
      end
      FS_R: begin
        sym_nxt = SYM_R;
        state_d = FS_IDLE;
      end
      default: state_d = FS_IDLE;
    endcase
    if (smp.raw) state_d = FS_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= FS_IDLE;
    else        state_q <= state_d;
  end

  // R8
  short_frame_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FS_K && !smp.en && !smp.raw) |=> (state_q == FS_T));
endmodule

// File: rtl/tx_4b5b_framer.sv
module tx_4b5b_framer
  import tx4b5b_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] mii_txd,
  input  logic       mii_tx_en,
  input  logic       mii_tx_er,
  input  logic       sym_raw,
  output logic [4:0] code_o
);
  samp_t in_s, s1;
  sym_t  fr_sym, code_q;
  logic  framed_q;

  assign in_s = '{en: mii_tx_en, er: mii_tx_er, raw: sym_raw, dat: mii_txd};

  tx_in_stage u_in (.clk(clk), .rst_n(rst_n), .in_s(in_s), .out_s(s1));
  frame_ctrl  u_fc (.clk(clk), .rst_n(rst_n), .smp(s1), .sym_nxt(fr_sym));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q   <= SYM_IDLE;
      framed_q <= 1'b1;
    end else begin
      code_q   <= s1.raw ? {s1.er, s1.dat} : fr_sym;
      framed_q <= !s1.raw;
    end
  end

  assign code_o = code_q;

  // R3
  k_follows_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (framed_q && code_q == SYM_J) |=> (!framed_q || code_q == SYM_K));
  // R5
  r_follows_t_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (framed_q && code_q == SYM_T) |=> (!framed_q || code_q == SYM_R));
  // R2
  idle_exit_is_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (framed_q && code_q == SYM_IDLE) |=>
      (!framed_q || code_q == SYM_IDLE || code_q == SYM_J));
  // R7
  bad_needs_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (framed_q && code_q == SYM_BAD) |-> $past(mii_tx_er, 2));
  // R9
  raw_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!framed_q) |-> (code_q == {$past(mii_tx_er, 2), $past(mii_txd, 2)}));
endmodule

// File: tb/tb_tx_4b5b_framer.sv
module tb_tx_4b5b_framer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] mii_txd = '0;
  logic       mii_tx_en = 1'b0;
  logic       mii_tx_er = 1'b0;
  logic       sym_raw = 1'b0;
  logic [4:0] code_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [4:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  tx_4b5b_framer dut (
    .clk(clk), .rst_n(rst_n), .mii_txd(mii_txd), .mii_tx_en(mii_tx_en),
    .mii_tx_er(mii_tx_er), .sym_raw(sym_raw), .code_o(code_o)
  );

  function automatic logic [4:0] ref_enc(input logic [3:0] n);
    case (n)
      4'h0: return 5'b11110;  4'h1: return 5'b01001;
      4'h2: return 5'b10100;  4'h3: return 5'b10101;
      4'h4: return 5'b01010;  4'h5: return 5'b01011;
      4'h6: return 5'b01110;  4'h7: return 5'b01111;
      4'h8: return 5'b10010;  4'h9: return 5'b10011;
      4'hA: return 5'b10110;  4'hB: return 5'b10111;
      4'hC: return 5'b11010;  4'hD: return 5'b11011;
      4'hE: return 5'b11100;  default: return 5'b11101;
    endcase
  endfunction

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: code_o=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: output now belongs to the drive made two negedges ago
  always @(negedge clk) begin
    if (rst_n && exp_q.size() >= 2) begin
      automatic logic [4:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      check(t, code_o, e);
    end
  end

  task automatic drive(input logic en, input logic er, input logic raw,
                       input logic [3:0] d, input logic [4:0] e, input string t);
    @(negedge clk);
    #1;
    mii_tx_en = en; mii_tx_er = er; sym_raw = raw; mii_txd = d;
    exp_q.push_back(e); tag_q.push_back(t);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 1'b0, 4'h0, 5'b11111, "R2");
  endtask

  task automatic frame(input int n, input int err_at, input logic [3:0] base);
    int len;
    len = ((n < 2) ? 2 : n) + 2;
    for (int i = 0; i < len; i++) begin
      logic [4:0] e;
      string t;
      logic [3:0] d;
      d = base + 4'(i);
      if (i == 0)      begin e = 5'b11000; t = "R6 R3 J"; end
      else if (i == 1) begin e = 5'b10001; t = (err_at == 1) ? "R10 K" : "R3 K"; end
      else if (i < n)  begin
        e = (i == err_at) ? 5'b00100 : ref_enc(d);
        t = (i == err_at) ? "R7 halt" : "R4 data";
      end
      else if (i == len - 2) begin e = 5'b01101; t = (n < 3) ? "R8 T" : "R5 T"; end
      else             begin e = 5'b00111; t = (n < 3) ? "R8 R" : "R5 R"; end
      drive(i < n, (i == err_at) && (i < n), 1'b0, d, e, t);
    end
  endtask

  task automatic rawsym(input logic [4:0] s);
    drive(1'b0, s[4], 1'b1, s[3:0], s, "R9 raw");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", code_o, 5'b11111);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 post-reset", code_o, 5'b11111);
    idle(4);
    frame(8, -1, 4'h5);
    idle(3);
    frame(18, -1, 4'hE);
    idle(2);
    frame(7, 4, 4'h3);
    idle(2);
    frame(5, 1, 4'h9);
    idle(2);
    frame(1, -1, 4'h0);
    idle(2);
    frame(2, -1, 4'h6);
    idle(2);
    rawsym(5'b10101);
    rawsym(5'b00000);
    rawsym(5'b11000);
    rawsym(5'b01101);
    idle(3);
    frame(4, -1, 4'hA);
    idle(4);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule